// File: doc/BRIEF.md
# Transceiver Power-Down Mode Controller

This block holds the power-down configuration of a transceiver and turns it into enable lines for each converter path and for the shared analog support. Software writes two configuration registers through a plain address/data port. A mode register sets which power-down modes are wanted. A channel register switches off single converter paths. An external power-down pin, which may toggle at any time, is brought into the clock domain through a synchronizer.

One bit of the mode register picks the role of the other mode bits. With the bit set, each mode bit switches its mode on directly and the pin plays no part. With the bit clear, the mode bits only arm modes, and an armed mode takes effect only while the synchronized pin is high. A self-clearing software reset bit returns every register to its default, including the reset bit itself.

Top module: `pwrdn_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, both configuration registers hold 0x00, every enable output is 1, and every read returns 0x00.
- R2: The mode register at 0x207 reads back what was written, with bit 1 forced to 0. The channel register at 0x208 reads back bits 7..4 as written, with bits 3..0 forced to 0.
- R3: Any address other than 0x207 and 0x208 reads 0x00, and a write to such an address changes no register and no output.
- R4: A write to 0x000 with bit 0 = 1 clears both configuration registers on the next clock edge after the write edge. Address 0x000 always reads 0x00. A write to 0x000 with bit 0 = 0 has no effect.
- R5: When mode bit 7 (source select) is 1, mode bits 6, 5, 4, 3, 2 and 0 act directly, and the pin has no effect on any output.
- R6: When mode bit 7 is 0, a set mode bit acts only while the synchronized pin is high. A pin change reaches the outputs after two rising clock edges and not after one.
- R7: Fast power-down (mode bit 6) clears all four converter enables. It leaves `ref_en`, `rx_oclk_en` and `rx_clkpath_en` at 1.
- R8: Global power-down (mode bit 5) clears every enable output, including the reference and both clock enables.
- R9: Q power-down (mode bit 4) clears `tx_q_en` and `rx_q_en`. I power-down (mode bit 3) clears `tx_i_en` and `rx_i_en`.
- R10: RX power-down (mode bit 2) clears `rx_i_en` and `rx_q_en` and keeps `rx_clkpath_en` at 1. TX power-down (mode bit 0) clears `tx_i_en` and `tx_q_en`.
- R11: Channel-register bits 7 (TX I), 6 (TX Q), 5 (RX I) and 4 (RX Q) each clear their own converter enable, whatever the source select and the pin are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| pdn_pin | input | 1 | Asynchronous external power-down pin |
| tx_i_en | output | 1 | TX I converter enable |
| tx_q_en | output | 1 | TX Q converter enable |
| rx_i_en | output | 1 | RX I converter enable |
| rx_q_en | output | 1 | RX Q converter enable |
| ref_en | output | 1 | Reference circuitry enable |
| rx_oclk_en | output | 1 | RX output clock enable |
| rx_clkpath_en | output | 1 | RX clock path enable |

## Verification
The assertions check on every cycle that reserved bits and unmapped addresses read 0, that a lost reference implies every other enable is lost, that fast power-down keeps the reference and output clock, that an idle pin with nothing forced leaves everything enabled, and that a software reset clears both registers within two edges. Only the bench's scenarios can show the full mapping from mode bits, channel bits, source select and pin level to the seven enables. It sweeps every combination of these. The bench scenarios also show the exact two-edge pin latency and show that writes to 0x000 with bit 0 clear, and writes to unmapped addresses, leave the stored state untouched.

// File: rtl/pwrdn_pkg.sv
`timescale 1ns/1ps
package pwrdn_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADR_SWRST = 12'h000;
    localparam logic [ADDR_W-1:0] ADR_MODE  = 12'h207;
    localparam logic [ADDR_W-1:0] ADR_CHAN  = 12'h208;

    localparam logic [DATA_W-1:0] MODE_MASK = 8'hFD;
    localparam logic [DATA_W-1:0] CHAN_MASK = 8'hF0;

    // Decoded mode register (reserved bit 1 dropped)
    typedef struct packed {
        logic src;
        logic fast;
        logic glob;
        logic qch;
        logic ich;
        logic rx;
        logic tx;
    } mode_t;

    // Decoded channel register (upper nibble)
    typedef struct packed {
        logic tx_i;
        logic tx_q;
        logic rx_i;
        logic rx_q;
    } chan_t;

    // Modes in force after source selection
    typedef struct packed {
        logic fast;
        logic glob;
        logic qch;
        logic ich;
        logic rx;
        logic tx;
    } act_t;

    typedef struct packed {
        logic tx_i;
        logic tx_q;
        logic rx_i;
        logic rx_q;
        logic ref_on;
        logic rx_oclk;
        logic rx_clkpath;
    } en_t;

    function automatic mode_t decode_mode(logic [DATA_W-1:0] r);
        return mode_t'({r[7:2], r[0]});
    endfunction

    function automatic act_t arm_modes(mode_t m, logic pin);
        logic gate;
        act_t a;
        gate   = m.src | pin;
        a.fast = m.fast & gate;
        a.glob = m.glob & gate;
        a.qch  = m.qch  & gate;
        a.ich  = m.ich  & gate;
        a.rx   = m.rx   & gate;
        a.tx   = m.tx   & gate;
        return a;
    endfunction

endpackage

// File: rtl/pwrdn_sync.sv
`timescale 1ns/1ps
module pwrdn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stg;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[k] <= 1'b0;
                else     stg[k] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[k] <= 1'b0;
                else     stg[k] <= stg[k-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/pwrdn_regs.sv
`timescale 1ns/1ps
module pwrdn_regs
    import pwrdn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] mode_r,
    output logic [DATA_W-1:0] chan_r
);
    logic sw_pulse;
    logic clr;

    assign clr = rst | sw_pulse;

    // Self-clearing reset: one-cycle pulse, cleared by itself
    always_ff @(posedge clk) begin
        if (clr) sw_pulse <= 1'b0;
        else     sw_pulse <= we && (addr == ADR_SWRST) && wdata[0];
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            mode_r <= '0;
            chan_r <= '0;
        end else if (we) begin
            if (addr == ADR_MODE) mode_r <= wdata & MODE_MASK;
            if (addr == ADR_CHAN) chan_r <= wdata & CHAN_MASK;
        end
    end

    always_comb begin
        unique case (addr)
            ADR_MODE: rdata = mode_r;
            ADR_CHAN: rdata = chan_r;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/pwrdn_resolve.sv
`timescale 1ns/1ps
module pwrdn_resolve
    import pwrdn_pkg::*;
(
    input  logic [DATA_W-1:0] mode_r,
    input  logic [DATA_W-1:0] chan_r,
    input  logic              pin_s,
    output en_t               en
);
    mode_t m;
    chan_t c;
    act_t  a;
    logic  path_off;

    assign m = decode_mode(mode_r);
    assign c = chan_t'(chan_r[7:4]);
    assign a = arm_modes(m, pin_s);
    assign path_off = a.glob | a.fast;

    always_comb begin
        en.tx_i       = ~(path_off | a.tx | a.ich | c.tx_i);
        en.tx_q       = ~(path_off | a.tx | a.qch | c.tx_q);
        en.rx_i       = ~(path_off | a.rx | a.ich | c.rx_i);
        en.rx_q       = ~(path_off | a.rx | a.qch | c.rx_q);
        en.ref_on     = ~a.glob;
        en.rx_oclk    = ~a.glob;
        en.rx_clkpath = ~a.glob;
    end
endmodule

// File: rtl/pwrdn_ctrl.sv
`timescale 1ns/1ps
module pwrdn_ctrl
    import pwrdn_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              pdn_pin,
    output logic              tx_i_en,
    output logic              tx_q_en,
    output logic              rx_i_en,
    output logic              rx_q_en,
    output logic              ref_en,
    output logic              rx_oclk_en,
    output logic              rx_clkpath_en
);
    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] chan_q;
    logic              pin_s;
    en_t               en;

    pwrdn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pdn_pin),
        .dout (pin_s)
    );

    pwrdn_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .we     (reg_we),
        .rdata  (reg_rdata),
        .mode_r (mode_q),
        .chan_r (chan_q)
    );

    pwrdn_resolve u_res (
        .mode_r (mode_q),
        .chan_r (chan_q),
        .pin_s  (pin_s),
        .en     (en)
    );

    assign tx_i_en       = en.tx_i;
    assign tx_q_en       = en.tx_q;
    assign rx_i_en       = en.rx_i;
    assign rx_q_en       = en.rx_q;
    assign ref_en        = en.ref_on;
    assign rx_oclk_en    = en.rx_oclk;
    assign rx_clkpath_en = en.rx_clkpath;
endmodule

// File: rtl/pwrdn_ctrl_chk.sv
`timescale 1ns/1ps
module pwrdn_ctrl_chk
    import pwrdn_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [DATA_W-1:0] mode_q,
    input logic [DATA_W-1:0] chan_q,
    input logic              pin_s,
    input logic              tx_i_en,
    input logic              tx_q_en,
    input logic              rx_i_en,
    input logic              rx_q_en,
    input logic              ref_en,
    input logic              rx_oclk_en,
    input logic              rx_clkpath_en
);
    logic [6:0] all_en;
    assign all_en = {tx_i_en, tx_q_en, rx_i_en, rx_q_en, ref_en, rx_oclk_en, rx_clkpath_en};

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (mode_q == '0 && chan_q == '0));

    assert_mode_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADR_MODE) |-> (reg_rdata[1] == 1'b0));

    assert_chan_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADR_CHAN) |-> (reg_rdata[3:0] == 4'h0));

    assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_addr != ADR_MODE && reg_addr != ADR_CHAN) |-> (reg_rdata == '0));

    assert_swrst_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == ADR_SWRST && reg_wdata[0]) |-> ##2 (mode_q == '0 && chan_q == '0));

    assert_src_pin_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q[7] && $stable(mode_q) && $stable(chan_q)) |-> $stable(all_en));

    assert_idle_pin_all_on_R6: assert property (@(posedge clk) disable iff (rst)
        (!mode_q[7] && !pin_s && chan_q[7:4] == 4'h0) |-> (all_en == 7'h7F));

    assert_fast_keeps_ref_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q[7] && mode_q[6] && !mode_q[5]) |-> (all_en == 7'b0000111));

    assert_global_all_off_R8: assert property (@(posedge clk) disable iff (rst)
        !ref_en |-> (all_en == 7'h00));
endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk u_chk (.*);

// File: tb/tb_pwrdn_ctrl.sv
`timescale 1ns/1ps
module tb_pwrdn_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_rdata;
    logic        pdn_pin = 1'b0;
    logic        tx_i_en, tx_q_en, rx_i_en, rx_q_en, ref_en, rx_oclk_en, rx_clkpath_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwrdn_ctrl dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .pdn_pin(pdn_pin),
        .tx_i_en(tx_i_en), .tx_q_en(tx_q_en), .rx_i_en(rx_i_en), .rx_q_en(rx_q_en),
        .ref_en(ref_en), .rx_oclk_en(rx_oclk_en), .rx_clkpath_en(rx_clkpath_en)
    );

    function automatic logic [6:0] outs();
        return {tx_i_en, tx_q_en, rx_i_en, rx_q_en, ref_en, rx_oclk_en, rx_clkpath_en};
    endfunction

    // Expected enables from requirement text; m = {fast,glob,q,i,rx,tx}
    function automatic logic [6:0] expect_en(bit src, bit pin, logic [5:0] m, logic [3:0] c);
        bit on = src || pin;
        bit fa = m[5] && on, gl = m[4] && on, q = m[3] && on;
        bit i = m[2] && on, rx = m[1] && on, tx = m[0] && on;
        logic [6:0] e;
        e[6] = !(gl || fa || tx || i || c[3]);
        e[5] = !(gl || fa || tx || q || c[2]);
        e[4] = !(gl || fa || rx || i || c[1]);
        e[3] = !(gl || fa || rx || q || c[0]);
        e[2] = !gl;
        e[1] = !gl;
        e[0] = !gl;
        return e;
    endfunction

    function automatic string tag_for(bit src, bit pin, logic [5:0] m, logic [3:0] c);
        bit on = src || pin;
        if (!src && !pin && m != 0) return "R6";
        if (on && m[4]) return "R8";
        if (on && m[5]) return "R7";
        if (c != 0) return "R11";
        if (on && (m[3] || m[2])) return "R9";
        if (on && (m[1] || m[0])) return "R10";
        return src ? "R5" : "R6";
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(string tag, logic [11:0] a, logic [7:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {1'b0, outs()}, 8'h7F);
        rd_check("R1", 12'h207, 8'h00);
        rd_check("R1", 12'h208, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {1'b0, outs()}, 8'h7F);

        // R2: readback masking
        wr(12'h207, 8'hFF);
        rd_check("R2", 12'h207, 8'hFD);
        wr(12'h208, 8'hFF);
        rd_check("R2", 12'h208, 8'hF0);
        wr(12'h207, 8'h00);
        rd_check("R2", 12'h207, 8'h00);

        // R3: unmapped address
        wr(12'h208, 8'h50);
        wr(12'h123, 8'hFF);
        rd_check("R3", 12'h123, 8'h00);
        rd_check("R3", 12'h209, 8'h00);
        rd_check("R3", 12'h207, 8'h00);
        rd_check("R3", 12'h208, 8'h50);
        check("R3", {1'b0, outs()}, 8'h57);

        // R4: soft reset
        wr(12'h207, 8'hA5);
        wr(12'h000, 8'hFE);
        rd_check("R4", 12'h207, 8'hA5);
        rd_check("R4", 12'h208, 8'h50);
        rd_check("R4", 12'h000, 8'h00);
        wr(12'h000, 8'h01);
        @(negedge clk);
        rd_check("R4", 12'h207, 8'h00);
        rd_check("R4", 12'h208, 8'h00);
        rd_check("R4", 12'h000, 8'h00);
        check("R4", {1'b0, outs()}, 8'h7F);

        // R6: pin latency with global armed
        wr(12'h207, 8'h20);
        check("R6", {1'b0, outs()}, 8'h7F);
        pdn_pin = 1'b1;
        @(negedge clk);
        check("R6", {1'b0, outs()}, 8'h7F);
        @(negedge clk);
        check("R6", {1'b0, outs()}, 8'h00);
        pdn_pin = 1'b0;
        repeat (2) @(negedge clk);
        check("R6", {1'b0, outs()}, 8'h7F);

        // Exhaustive sweep over pin, source, modes and channel bits
        for (int p = 0; p < 2; p++) begin
            pdn_pin = p[0];
            repeat (3) @(negedge clk);
            for (int s = 0; s < 2; s++) begin
                for (int m = 0; m < 64; m++) begin
                    logic [5:0] mb = m[5:0];
                    wr(12'h207, {s[0], mb[5:1], 1'b0, mb[0]});
                    for (int c = 0; c < 16; c++) begin
                        wr(12'h208, {c[3:0], 4'h0});
                        check(tag_for(s[0], p[0], mb, c[3:0]), {1'b0, outs()},
                              {1'b0, expect_en(s[0], p[0], mb, c[3:0])});
                    end
                end
            end
        end

        // R5: pin toggle with source select set has no effect
        wr(12'h208, 8'h00);
        wr(12'h207, 8'h84);
        pdn_pin = 1'b0;
        repeat (3) @(negedge clk);
        check("R5", {1'b0, outs()}, 8'h67);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule